// File: doc/BRIEF.md
# Shared message-signaled interrupt register bank

This block holds a small set of message registers that collect message-signaled interrupts from a shared doorbell. Each message register is 32 bits wide. An agent signals an interrupt by writing one word to a single index register. The upper bits of that word pick the message register, and the next field picks which bit in it to set. Every message register drives its own level interrupt line toward the interrupt source logic. The line stays high while the register holds any set bit.

A service routine reads a message register to learn which messages arrived. The read returns the collected bits and clears the register in the same access, which drops its line. A status word shows at once which message registers are non-empty. The write port and the read port are separate. A doorbell write and a clear-on-read can therefore land on the same register in the same cycle, and the bank defines what happens then.

Top module: `msi_bank`

## Requirements
- R1: After a synchronous active-low reset, every message register is zero and every interrupt line is low.
- R2: A write to offset 0x140 sets bit `wr_data[28:24]` of message register `wr_data[31:29]`. The change and the rise of that register's line take effect at the clock edge that accepts the write. Bits 23:0 of the written word have no effect.
- R3: Message register n sits at offset n*0x10 (n = 0..7). A read there returns its value in the same cycle. At that edge the register is cleared to zero and line n goes low.
- R4: A read at offset 0x120 returns a word whose bit i is 1 exactly when message register i is nonzero. All bits from 8 upward are 0.
- R5: When bits 3:0 of the address are not all zero, a read returns 0xFFFFFFFF and clears nothing, and a write changes nothing.
- R6: A write to any aligned offset other than 0x140 has no effect on any register or line.
- R7: A read of an aligned offset that is neither a message register nor the status word returns zero. Offset 0x140 counts as such an offset. This read clears nothing.
- R8: If a doorbell write and a read of the same message register fall in the same cycle, the read returns the old value. The register then holds only the newly set bit, and its line stays high.
- R9: Doorbell writes accumulate. Each write ORs one bit into its register and leaves the other bits and the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (clear-on-read side effect) |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, valid in the cycle rd_en is high |
| irq | output | 8 | One level interrupt line per message register |

## Verification
The doorbell path is swept over every register and bit pair. Each write carries a different junk pattern in its low 24 bits. Each pair is then read back through the status word and through the register itself, which shows whether the register and bit fields were decoded into the right place and whether the clear works. Multi-bit accumulation is compared against a running model of all eight registers, which catches cross-register corruption. Every aligned offset is read. Misaligned and non-index writes are then replayed while the model is checked again, which separates ignored accesses from ones that wrongly clear or set state. Same-cycle set and clear is tried on the same register and on different registers, which tells a correctly ordered merge apart from one that lets the clear win.

// File: rtl/msi_bank_pkg.sv
// Shared constants and helpers for the message-signaled interrupt bank.
// Assumes byte offsets with 16-byte register spacing.
package msi_bank_pkg;
    // Low address bits that must be zero for a legal access.
    localparam int unsigned ALIGN_BITS = 4;

    // Returns a word with a single bit set at position idx.
    function automatic logic [31:0] bit_of(input logic [4:0] idx);
        bit_of = 32'd1 << idx;
    endfunction
endpackage

// File: rtl/msi_addr_decode.sv
// Decodes one byte offset into the hit lines of the bank.
// Assumes: message register i at i << ALIGN_BITS, plus one status
// offset and one index offset. Purely combinational.
module msi_addr_decode
    import msi_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_REGS   = 8,
    parameter int unsigned STATUS_OFS = 'h120,
    parameter int unsigned INDEX_OFS  = 'h140
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                aligned,
    output logic [NUM_REGS-1:0] msg_hit,
    output logic                status_hit,
    output logic                index_hit
);
    // Alignment check on the low address bits.
    always_comb aligned = (addr[ALIGN_BITS-1:0] == '0);

    // One comparator per message register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_msg
        assign msg_hit[i] = aligned && (addr == ADDR_W'(i << ALIGN_BITS));
    end

    // Fixed global offsets.
    always_comb begin
        status_hit = aligned && (addr == ADDR_W'(STATUS_OFS));
        index_hit  = aligned && (addr == ADDR_W'(INDEX_OFS));
    end
endmodule

// File: rtl/msi_reg_slice.sv
// One message register and its interrupt line.
// A set ORs one bit in; a clear empties the register; when both come
// together the clear applies to the old contents and the new bit survives.
module msi_reg_slice #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [BIT_W-1:0]  set_idx,
    input  logic              clr_en,
    output logic [DATA_W-1:0] value,
    output logic              line
);
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] kept;

    // Decode the bit to set and the part of the register that survives.
    always_comb begin
        set_mask = set_en ? (DATA_W'(1) << set_idx) : '0;
        kept     = clr_en ? '0 : value;
    end

    // Register update: clear first, then merge the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= kept | set_mask;
    end

    // Level line follows non-empty contents.
    always_comb line = |value;

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> value[$past(set_idx)]);
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (value == '0) && !line);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en) |=> ($countones(value) == 1) && line);
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !set_en) |=> $stable(value));
endmodule

// File: rtl/msi_read_mux.sv
// Read data selection for the bank.
// Misaligned reads give all ones, message offsets give the register,
// the status offset gives the non-empty summary, anything else zero.
module msi_read_mux #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                             rd_en,
    input  logic                             aligned,
    input  logic [NUM_REGS-1:0]              msg_hit,
    input  logic                             status_hit,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
    output logic [DATA_W-1:0]                rd_data
);
    logic [DATA_W-1:0] msg_word;
    logic [DATA_W-1:0] status_word;

    // OR-combine the one-hot selected register and build the summary.
    always_comb begin
        msg_word    = '0;
        status_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (msg_hit[i]) msg_word = msg_word | values[i];
            status_word[i] = |values[i];
        end
    end

    // Final priority selection.
    always_comb begin
        if (!rd_en)          rd_data = '0;
        else if (!aligned)   rd_data = '1;
        else if (|msg_hit)   rd_data = msg_word;
        else if (status_hit) rd_data = status_word;
        else                 rd_data = '0;
    end
endmodule

// File: rtl/msi_bank.sv
// Top of the shared message-signaled interrupt register bank.
// Assumes separate read and write ports that may both be active in
// one cycle; reads have a clear side effect on message registers.
module msi_bank
    import msi_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_REGS   = 8,
    parameter int unsigned STATUS_OFS = 'h120,
    parameter int unsigned INDEX_OFS  = 'h140
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_REGS-1:0] irq
);
    localparam int unsigned SEL_W   = $clog2(NUM_REGS);
    localparam int unsigned BIT_W   = $clog2(DATA_W);
    localparam int unsigned SEL_TOP = DATA_W - 1;
    localparam int unsigned BIT_TOP = DATA_W - 1 - SEL_W;

    logic                wr_aligned, wr_status_hit, wr_index_hit;
    logic [NUM_REGS-1:0] wr_msg_hit;
    logic                rd_aligned, rd_status_hit, rd_index_hit;
    logic [NUM_REGS-1:0] rd_msg_hit;
    logic [SEL_W-1:0]    wr_sel;
    logic [BIT_W-1:0]    wr_bit;
    logic [NUM_REGS-1:0] set_en;
    logic [NUM_REGS-1:0] clr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] values;

    msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                      .STATUS_OFS(STATUS_OFS), .INDEX_OFS(INDEX_OFS)) u_wr_dec (
        .addr(wr_addr), .aligned(wr_aligned), .msg_hit(wr_msg_hit),
        .status_hit(wr_status_hit), .index_hit(wr_index_hit)
    );

    msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                      .STATUS_OFS(STATUS_OFS), .INDEX_OFS(INDEX_OFS)) u_rd_dec (
        .addr(rd_addr), .aligned(rd_aligned), .msg_hit(rd_msg_hit),
        .status_hit(rd_status_hit), .index_hit(rd_index_hit)
    );

    // Split the doorbell word into register and bit selects.
    always_comb begin
        wr_sel = wr_data[SEL_TOP -: SEL_W];
        wr_bit = wr_data[BIT_TOP -: BIT_W];
    end

    // Per-register slices with their set and clear strobes.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign set_en[i] = wr_en && wr_index_hit && (wr_sel == SEL_W'(i));
        assign clr_en[i] = rd_en && rd_msg_hit[i];

        msi_reg_slice #(.DATA_W(DATA_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .set_en(set_en[i]), .set_idx(wr_bit), .clr_en(clr_en[i]),
            .value(values[i]), .line(irq[i])
        );
    end

    msi_read_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_mux (
        .rd_en(rd_en), .aligned(rd_aligned), .msg_hit(rd_msg_hit),
        .status_hit(rd_status_hit), .values(values), .rd_data(rd_data)
    );

    assert_status_matches_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_status_hit) |-> (rd_data[NUM_REGS-1:0] == irq));
    assert_misaligned_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_aligned) |-> (rd_data == '1));
    assert_other_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_index_hit && !rd_en) |=> $stable(irq));
    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_en));
endmodule

// File: tb/msi_bank_tb_top.sv
// Self-checking bench: sweeps every register/bit doorbell, accumulation,
// address corners and same-cycle set/clear against a bench model.
module msi_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m [8];

    always #5 clk = ~clk;

    msi_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_lines();
        logic [7:0] e;
        for (int i = 0; i < 8; i++) e[i] = (m[i] != 0);
        return e;
    endfunction

    function automatic logic [31:0] doorbell(input int r, input int b, input logic [23:0] junk);
        return (32'(r) << 29) | (32'(b) << 24) | 32'(junk);
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 12'h140) m[d[31:29]] = m[d[31:29]] | (32'd1 << d[28:24]);
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        if (a[3:0] == 0 && a < 12'h080) m[a[6:4]] = '0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk(tag, {24'd0, irq}, {24'd0, exp_lines()});
        do_read(12'h120, d);
        chk(tag, d, {24'd0, exp_lines()});
        for (int i = 0; i < 8; i++) begin
            logic [31:0] e;
            e = m[i];
            do_read(12'(i * 16), d);
            chk(tag, d, e);
        end
        chk(tag, {24'd0, irq}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 lines", {24'd0, irq}, 32'd0);
        check_all("R1 contents");

        // R2/R3/R4: every register x every bit, junk in low bits
        for (int r = 0; r < 8; r++) begin
            for (int b = 0; b < 32; b++) begin
                do_write(12'h140, doorbell(r, b, 24'(r * 7919 + b * 104729)));
                chk("R2 line", {24'd0, irq}, 32'd1 << r);
                do_read(12'h120, d);
                chk("R4 status", d, 32'd1 << r);
                do_read(12'(r * 16), d);
                chk("R3 value", d, 32'd1 << b);
                chk("R3 line cleared", {24'd0, irq}, 32'd0);
            end
        end

        // R9: accumulation across registers
        for (int k = 0; k < 40; k++) begin
            do_write(12'h140, doorbell((k * 3) % 8, (k * 11) % 32, 24'hFFFFFF));
            if (k % 10 == 9) check_all("R9 accumulate");
        end
        do_write(12'h140, doorbell(5, 7, 0));
        do_write(12'h140, doorbell(5, 7, 0));
        do_write(12'h140, doorbell(2, 31, 0));
        check_all("R9 repeat bit");

        // R5: misaligned reads and writes
        do_write(12'h140, doorbell(0, 3, 0));
        for (int k = 1; k < 16; k++) begin
            do_read(12'(k), d);
            chk("R5 misaligned read", d, 32'hFFFFFFFF);
            do_read(12'h140 + 12'(k), d);
            chk("R5 misaligned read", d, 32'hFFFFFFFF);
            do_write(12'h140 + 12'(k), doorbell(k % 8, k, 0));
        end
        check_all("R5 nothing changed");

        // R6: writes to every other aligned offset
        do_write(12'h140, doorbell(6, 12, 0));
        do_write(12'h140, doorbell(1, 0, 0));
        for (int a = 0; a < 256; a++) begin
            if (a != 'h14) do_write(12'(a * 16), doorbell(a % 8, a % 32, 24'hABCDEF));
        end
        check_all("R6 writes ignored");

        // R7: unused aligned offsets read zero and clear nothing
        do_write(12'h140, doorbell(4, 20, 0));
        do_write(12'h140, doorbell(7, 1, 0));
        for (int a = 8; a < 256; a++) begin
            if (a != 'h12) begin
                do_read(12'(a * 16), d);
                chk("R7 unused read", d, 32'd0);
            end
        end
        check_all("R7 nothing cleared");

        // R8: same-cycle set and clear on one register
        do_write(12'h140, doorbell(3, 5, 0));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h140; wr_data = doorbell(3, 9, 0);
        rd_en = 1'b1; rd_addr = 12'h030;
        #1 chk("R8 old value", rd_data, 32'd1 << 5);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        m[3] = 32'd1 << 9;
        chk("R8 line held", {24'd0, irq}, 32'd1 << 3);
        check_all("R8 new bit only");

        // R8: same-cycle set and clear on different registers
        do_write(12'h140, doorbell(0, 2, 0));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h140; wr_data = doorbell(6, 30, 0);
        rd_en = 1'b1; rd_addr = 12'h000;
        #1 chk("R8 other reg read", rd_data, 32'd1 << 2);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        m[0] = '0; m[6] = m[6] | (32'd1 << 30);
        check_all("R8 other reg");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule